// File: doc/BRIEF.md
# NAND Flash Command Interface

This block is the device-side front end of a small-page NAND memory. The host drives an 8-bit bus together with command-latch and address-latch qualifiers. A byte is captured on the rising edge of the write strobe. A command byte selects the operation, and address and data bytes then feed the column pointer, the page address or the page register. Read strobes step data out of the page register one byte at a time, or return a status byte or a two-byte identifier. A ready/busy output is low while an internal read, program or erase is running.

Each page is 528 bytes. Columns 0-255 form the lower main half, columns 256-511 the upper main half, and columns 512-527 the spare area. Three read commands choose which region the column byte is offset into. The cell array is a small register array, and every busy period is a parameterised count of clock cycles. Programming can only clear bits: the array byte is ANDed with the page-register byte. Erase sets every page of a block back to FFh.

Top module: `nandCmdFront`

## Requirements
- R1: After reset the ready/busy output is high, and a status command (70h) followed by a read strobe returns C0h.
- R2: Command 90h followed by one address byte returns 98h on the first read strobe and 75h on the second.
- R3: Command 80h, then three address bytes (column, page low, page high), then data bytes, then 10h holds ready/busy low for PROG_CYCLES cycles. The array byte then becomes the old array byte ANDed with the written byte. Data bytes load the page register starting at the selected column and stepping upward.
- R4: Command 01h offsets the column byte by 256. This selection applies to one operation only, and the next operation uses offset 0 unless 01h or 50h is given again.
- R5: Command 50h sets the column to 512 plus the low four bits of the column byte. This selection stays in force for later operations until 00h is issued. Command 00h uses offset 0.
- R6: A read (00h/01h/50h) starts busy on the third address byte, and the page is readable once ready/busy returns high. A fourth address byte is ignored.
- R7: Reading past column 527 starts a new busy period and moves on to the next page. In 00h/01h mode that page starts at column 0, and in 50h mode at column 512.
- R8: Command 60h, then two page-address bytes, then D0h erases every page of the block holding that page (2 pages per block by default), setting them to FFh. Other blocks keep their data.
- R9: The status byte has bit 7 set when write-protect is high, bit 6 set when ready, and bit 0 holding the fail flag only while ready. All other bits read zero. Status can be read while busy.
- R10: With write-protect low, a 10h or D0h confirm does not start and the fail flag is set.
- R11: Write-protect going low during a program or erase ends it at once and sets fail. The array stays unchanged.
- R12: Command FFh makes the device ready on the next cycle and aborts any program or erase without writing. It also clears fail and selects offset 0.
- R13: While busy, commands other than 70h and FFh are ignored, and so are address and data bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Active-low chip enable |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| weN | input | 1 | Write strobe, captures on rising edge |
| reN | input | 1 | Read strobe, advances on rising edge |
| wpN | input | 1 | Active-low write protect |
| ioIn | input | 8 | Command, address and data bus in |
| ioOut | output | 8 | Array data, status or identifier out |
| readyBusy | output | 1 | High when ready, low when busy |

## Verification
The hardest states to reach are the page-boundary wrap and an interrupted program. To reach the wrap, the bench starts reads near the end of a page in upper-half mode and in spare mode, then strobes through column 527. It confirms the new busy period, and that the next byte comes from the following page at column 0 or column 512. For interruptions, the bench starts a long program and, still inside its busy window, reads status and issues an identifier command that must be ignored. It then sends a reset and shows that the page was never written. A separate run drops write-protect partway through an erase.

// File: rtl/nandPkg.sv
package nandPkg;

  localparam logic [7:0] CMD_READ_A  = 8'h00;
  localparam logic [7:0] CMD_READ_B  = 8'h01;
  localparam logic [7:0] CMD_READ_C  = 8'h50;
  localparam logic [7:0] CMD_PROG    = 8'h80;
  localparam logic [7:0] CMD_PROG_GO = 8'h10;
  localparam logic [7:0] CMD_ERASE   = 8'h60;
  localparam logic [7:0] CMD_ERASE_GO= 8'hD0;
  localparam logic [7:0] CMD_STATUS  = 8'h70;
  localparam logic [7:0] CMD_ID      = 8'h90;
  localparam logic [7:0] CMD_RESET   = 8'hFF;

  typedef enum logic [1:0] {AREA_A, AREA_B, AREA_C} areaT;
  typedef enum logic [1:0] {OUT_ARRAY, OUT_STATUS, OUT_ID} outSelT;

  typedef struct packed {
    logic   loadCol;
    logic   loadPage;
    logic   writeData;
    logic   readAdvance;
    logic   fillPage;
    logic   fetchPage;
    logic   commitProgram;
    logic   eraseBlock;
    logic   idReset;
    logic   idAdvance;
    areaT   area;
    outSelT outSel;
  } dpStrobeT;

endpackage

// File: rtl/nandCtrl.sv
module nandCtrl
  import nandPkg::*;
#(
  parameter int READ_CYCLES  = 20,
  parameter int PROG_CYCLES  = 60,
  parameter int ERASE_CYCLES = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  input  logic       atLastCol,
  output dpStrobeT   strb,
  output logic       ready,
  output logic       fail
);

  localparam int MAX_CYC = (READ_CYCLES > PROG_CYCLES) ?
                           ((READ_CYCLES > ERASE_CYCLES) ? READ_CYCLES : ERASE_CYCLES) :
                           ((PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES);
  localparam int CNT_W = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_DATAIN, PH_ERADDR,
                            PH_IDADDR, PH_IDOUT, PH_READOUT} phaseT;
  typedef enum logic [1:0] {BZ_NONE, BZ_READ, BZ_PROG, BZ_ERASE} busyT;

  logic weNd, reNd;
  logic weRise, reRise, cmdLatch, addrLatch, dataLatch, busy;

  phaseT  phase, nxtPhase;
  logic   opIsRead, nxtOpIsRead;
  logic [1:0] addrCnt, nxtAddrCnt;
  areaT   area, nxtArea;
  outSelT outSel, nxtOutSel;
  busyT   busyKind, nxtBusyKind;
  logic [CNT_W-1:0] busyCnt, nxtBusyCnt;
  logic   nxtFail;

  assign weRise    = weN && !weNd && !ceN;
  assign reRise    = reN && !reNd && !ceN;
  assign cmdLatch  = weRise && cle && !ale;
  assign addrLatch = weRise && ale && !cle;
  assign dataLatch = weRise && !cle && !ale;
  assign busy      = (busyKind != BZ_NONE);
  assign ready     = !busy;

  always_comb begin
    nxtPhase    = phase;
    nxtOpIsRead = opIsRead;
    nxtAddrCnt  = addrCnt;
    nxtArea     = area;
    nxtOutSel   = outSel;
    nxtBusyKind = busyKind;
    nxtBusyCnt  = busyCnt;
    nxtFail     = fail;
    strb        = '0;
    strb.area   = area;
    strb.outSel = outSel;

    // running operation
    if (busy) begin
      if (!wpN && (busyKind == BZ_PROG || busyKind == BZ_ERASE)) begin
        nxtBusyKind = BZ_NONE;
        nxtFail     = 1'b1;
      end else if (busyCnt == '0) begin
        unique case (busyKind)
          BZ_READ:  begin strb.fetchPage = 1'b1; nxtPhase = PH_READOUT; end
          BZ_PROG:  strb.commitProgram = 1'b1;
          BZ_ERASE: strb.eraseBlock = 1'b1;
          default:  ;
        endcase
        nxtBusyKind = BZ_NONE;
      end else begin
        nxtBusyCnt = busyCnt - 1'b1;
      end
    end

    if (cmdLatch) begin
      if (ioIn == CMD_RESET) begin
        strb.fetchPage   = 1'b0;
        strb.commitProgram = 1'b0;
        strb.eraseBlock  = 1'b0;
        nxtBusyKind = BZ_NONE;
        nxtPhase    = PH_IDLE;
        nxtArea     = AREA_A;
        nxtFail     = 1'b0;
        nxtOutSel   = OUT_ARRAY;
      end else if (ioIn == CMD_STATUS) begin
        nxtOutSel = OUT_STATUS;
      end else if (!busy) begin
        unique case (ioIn)
          CMD_READ_A, CMD_READ_B, CMD_READ_C: begin
            nxtArea     = (ioIn == CMD_READ_A) ? AREA_A :
                          (ioIn == CMD_READ_B) ? AREA_B : AREA_C;
            nxtPhase    = PH_ADDR;
            nxtOpIsRead = 1'b1;
            nxtAddrCnt  = '0;
            nxtOutSel   = OUT_ARRAY;
          end
          CMD_PROG: begin
            nxtPhase      = PH_ADDR;
            nxtOpIsRead   = 1'b0;
            nxtAddrCnt    = '0;
            strb.fillPage = 1'b1;
            nxtOutSel     = OUT_ARRAY;
          end
          CMD_PROG_GO: if (phase == PH_DATAIN) begin
            if (wpN) begin
              nxtBusyKind = BZ_PROG;
              nxtBusyCnt  = CNT_W'(PROG_CYCLES - 1);
              nxtFail     = 1'b0;
            end else begin
              nxtFail = 1'b1;
            end
            nxtPhase = PH_IDLE;
            if (area == AREA_B) nxtArea = AREA_A;
          end
          CMD_ERASE: begin
            nxtPhase   = PH_ERADDR;
            nxtAddrCnt = '0;
          end
          CMD_ERASE_GO: if (phase == PH_ERADDR && addrCnt == 2'd2) begin
            if (wpN) begin
              nxtBusyKind = BZ_ERASE;
              nxtBusyCnt  = CNT_W'(ERASE_CYCLES - 1);
              nxtFail     = 1'b0;
            end else begin
              nxtFail = 1'b1;
            end
            nxtPhase = PH_IDLE;
          end
          CMD_ID: nxtPhase = PH_IDADDR;
          default: ;
        endcase
      end
    end else if (addrLatch && !busy) begin
      unique case (phase)
        PH_ADDR: begin
          if (addrCnt == 2'd0) strb.loadCol = 1'b1;
          if (addrCnt == 2'd1) strb.loadPage = 1'b1;
          if (addrCnt == 2'd2) begin
            if (opIsRead) begin
              nxtBusyKind = BZ_READ;
              nxtBusyCnt  = CNT_W'(READ_CYCLES - 1);
              nxtPhase    = PH_READOUT;
              if (area == AREA_B) nxtArea = AREA_A;
            end else begin
              nxtPhase = PH_DATAIN;
            end
          end
          nxtAddrCnt = addrCnt + 1'b1;
        end
        PH_ERADDR: begin
          if (addrCnt == 2'd0) strb.loadPage = 1'b1;
          if (addrCnt != 2'd2) nxtAddrCnt = addrCnt + 1'b1;
        end
        PH_IDADDR, PH_IDOUT: begin
          strb.idReset = 1'b1;
          nxtPhase     = PH_IDOUT;
          nxtOutSel    = OUT_ID;
        end
        default: ;
      endcase
    end else if (dataLatch && !busy && phase == PH_DATAIN) begin
      strb.writeData = 1'b1;
    end

    if (reRise && !busy && !cmdLatch) begin
      if (outSel == OUT_ARRAY && phase == PH_READOUT) begin
        strb.readAdvance = 1'b1;
        if (atLastCol) begin
          nxtBusyKind = BZ_READ;
          nxtBusyCnt  = CNT_W'(READ_CYCLES - 1);
        end
      end
      if (outSel == OUT_ID) strb.idAdvance = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weNd     <= 1'b1;
      reNd     <= 1'b1;
      phase    <= PH_IDLE;
      opIsRead <= 1'b0;
      addrCnt  <= '0;
      area     <= AREA_A;
      outSel   <= OUT_ARRAY;
      busyKind <= BZ_NONE;
      busyCnt  <= '0;
      fail     <= 1'b0;
    end else begin
      weNd     <= weN;
      reNd     <= reN;
      phase    <= nxtPhase;
      opIsRead <= nxtOpIsRead;
      addrCnt  <= nxtAddrCnt;
      area     <= nxtArea;
      outSel   <= nxtOutSel;
      busyKind <= nxtBusyKind;
      busyCnt  <= nxtBusyCnt;
      fail     <= nxtFail;
    end
  end

endmodule

// File: rtl/nandDatapath.sv
module nandDatapath
  import nandPkg::*;
#(
  parameter int PAGES           = 4,
  parameter int PAGES_PER_BLOCK = 2,
  parameter int MAIN_HALF       = 256,
  parameter int SPARE           = 16,
  parameter logic [7:0] ID_MAKER  = 8'h98,
  parameter logic [7:0] ID_DEVICE = 8'h75
) (
  input  logic       clk,
  input  logic       rstN,
  input  dpStrobeT   strb,
  input  logic [7:0] ioIn,
  input  logic       ready,
  input  logic       fail,
  input  logic       wpN,
  output logic [7:0] ioOut,
  output logic       atLastCol
);

  localparam int PAGE_BYTES = 2 * MAIN_HALF + SPARE;
  localparam int COL_W      = $clog2(PAGE_BYTES);
  localparam int PAGE_W     = $clog2(PAGES);
  localparam int PPB_W      = $clog2(PAGES_PER_BLOCK);
  localparam int SPARE_W    = $clog2(SPARE);
  localparam logic [COL_W-1:0] LAST_COL   = COL_W'(PAGE_BYTES - 1);
  localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2 * MAIN_HALF);

  logic [7:0] cells   [PAGES][PAGE_BYTES];
  logic [7:0] pageReg [PAGE_BYTES];
  logic [COL_W-1:0]  col;
  logic [PAGE_W-1:0] pageIdx;
  logic [PAGE_W-1:0] blockBase;
  logic [1:0]        idIdx;
  logic [7:0]        idByte, statusByte;

  assign atLastCol = (col == LAST_COL);
  assign blockBase = {pageIdx[PAGE_W-1:PPB_W], PPB_W'(0)};

  // pointer, page address and identifier index
  always_ff @(posedge clk) begin
    if (!rstN) begin
      col     <= '0;
      pageIdx <= '0;
      idIdx   <= '0;
    end else begin
      if (strb.loadCol) begin
        unique case (strb.area)
          AREA_B:  col <= COL_W'(MAIN_HALF) + COL_W'(ioIn);
          AREA_C:  col <= SPARE_BASE + COL_W'(ioIn[SPARE_W-1:0]);
          default: col <= COL_W'(ioIn);
        endcase
      end
      if (strb.loadPage) pageIdx <= ioIn[PAGE_W-1:0];
      if (strb.writeData && !atLastCol) col <= col + 1'b1;
      if (strb.readAdvance) begin
        if (atLastCol) begin
          col     <= (strb.area == AREA_C) ? SPARE_BASE : '0;
          pageIdx <= pageIdx + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
      if (strb.idReset) idIdx <= '0;
      else if (strb.idAdvance && idIdx != 2'd2) idIdx <= idIdx + 1'b1;
    end
  end

  // page register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
    end else if (strb.fillPage) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
    end else if (strb.fetchPage) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= cells[pageIdx][i];
    end else if (strb.writeData) begin
      pageReg[col] <= ioIn;
    end
  end

  // cell array
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int p = 0; p < PAGES; p++)
        for (int i = 0; i < PAGE_BYTES; i++) cells[p][i] <= 8'hFF;
    end else if (strb.commitProgram) begin
      for (int i = 0; i < PAGE_BYTES; i++)
        cells[pageIdx][i] <= cells[pageIdx][i] & pageReg[i];
    end else if (strb.eraseBlock) begin
      for (int j = 0; j < PAGES_PER_BLOCK; j++)
        for (int i = 0; i < PAGE_BYTES; i++)
          cells[blockBase + PAGE_W'(j)][i] <= 8'hFF;
    end
  end

  always_comb begin
    unique case (idIdx)
      2'd0:    idByte = ID_MAKER;
      2'd1:    idByte = ID_DEVICE;
      default: idByte = 8'h00;
    endcase
    statusByte = {wpN, ready, 5'b0, ready & fail};
    unique case (strb.outSel)
      OUT_STATUS: ioOut = statusByte;
      OUT_ID:     ioOut = idByte;
      default:    ioOut = pageReg[col];
    endcase
  end

endmodule

// File: rtl/nandCmdFront.sv
module nandCmdFront
  import nandPkg::*;
#(
  parameter int PAGES           = 4,
  parameter int PAGES_PER_BLOCK = 2,
  parameter int MAIN_HALF       = 256,
  parameter int SPARE           = 16,
  parameter int READ_CYCLES     = 20,
  parameter int PROG_CYCLES     = 60,
  parameter int ERASE_CYCLES    = 80
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       cle,
  input  logic       ale,
  input  logic       weN,
  input  logic       reN,
  input  logic       wpN,
  input  logic [7:0] ioIn,
  output logic [7:0] ioOut,
  output logic       readyBusy
);

  dpStrobeT strb;
  logic     atLastCol, ready, fail;

  assign readyBusy = ready;

  nandCtrl #(
    .READ_CYCLES(READ_CYCLES), .PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .wpN(wpN), .ioIn(ioIn), .atLastCol(atLastCol), .strb(strb), .ready(ready), .fail(fail)
  );

  nandDatapath #(
    .PAGES(PAGES), .PAGES_PER_BLOCK(PAGES_PER_BLOCK), .MAIN_HALF(MAIN_HALF), .SPARE(SPARE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ioIn(ioIn), .ready(ready), .fail(fail),
    .wpN(wpN), .ioOut(ioOut), .atLastCol(atLastCol)
  );

endmodule

// File: rtl/nandCmdFrontChecker.sv
module nandCmdFrontChecker (
  input logic       clk,
  input logic       rstN,
  input logic       ceN,
  input logic       cle,
  input logic       ale,
  input logic       weN,
  input logic       wpN,
  input logic [7:0] ioIn,
  input logic [7:0] ioOut,
  input logic       readyBusy
);

  logic       weNPrev;
  logic [7:0] lastCmd;
  logic [1:0] addrSeen;
  logic       weRiseC, cmdC, addrC, isReadCmd;

  assign weRiseC   = weN && !weNPrev && !ceN;
  assign cmdC      = weRiseC && cle && !ale;
  assign addrC     = weRiseC && ale && !cle;
  assign isReadCmd = (lastCmd == 8'h00) || (lastCmd == 8'h01) || (lastCmd == 8'h50);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      weNPrev  <= 1'b1;
      lastCmd  <= 8'hFF;
      addrSeen <= '0;
    end else begin
      weNPrev <= weN;
      if (cmdC && (readyBusy || ioIn == 8'h70 || ioIn == 8'hFF)) begin
        lastCmd  <= ioIn;
        addrSeen <= '0;
      end else if (addrC && addrSeen != 2'd3) begin
        addrSeen <= addrSeen + 1'b1;
      end
    end
  end

  AST_RESET_READY: assert property (@(posedge clk) disable iff (!rstN)
    (cmdC && ioIn == 8'hFF) |=> readyBusy);  // R12

  AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdC && ioIn == 8'h70) |=> (ioOut[7] == wpN && ioOut[6] == readyBusy && ioOut[5:1] == 5'd0));  // R9

  AST_WP_BLOCKS_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (cmdC && ioIn == 8'h10 && !wpN && readyBusy) |=> readyBusy);  // R10

  AST_ID_MAKER_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    (addrC && lastCmd == 8'h90 && readyBusy) |=> (ioOut == 8'h98));  // R2

  AST_THIRD_ADDR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (addrC && isReadCmd && addrSeen == 2'd2 && readyBusy) |=> !readyBusy);  // R6

endmodule

bind nandCmdFront nandCmdFrontChecker u_chk (
  .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .wpN(wpN),
  .ioIn(ioIn), .ioOut(ioOut), .readyBusy(readyBusy)
);

// File: tb/sim_nandCmdFront.sv
module sim_nandCmdFront;

  logic clk = 1'b0;
  logic rstN, ceN, cle, ale, weN, reN, wpN;
  logic [7:0] ioIn;
  logic [7:0] ioOut;
  logic readyBusy;
  int checks = 0;
  int failures = 0;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  nandCmdFront u0 (
    .clk(clk), .rstN(rstN), .ceN(ceN), .cle(cle), .ale(ale), .weN(weN), .reN(reN),
    .wpN(wpN), .ioIn(ioIn), .ioOut(ioOut), .readyBusy(readyBusy)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic busWrite(input logic c, input logic a, input logic [7:0] d);
    @(negedge clk);
    cle = c; ale = a; ioIn = d; weN = 1'b0;
    @(negedge clk);
    weN = 1'b1;
    @(negedge clk);
    cle = 1'b0; ale = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] d);  busWrite(1'b1, 1'b0, d); endtask
  task automatic adr(input logic [7:0] d);  busWrite(1'b0, 1'b1, d); endtask
  task automatic dat(input logic [7:0] d);  busWrite(1'b0, 1'b0, d); endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk);
    reN = 1'b0;
    @(negedge clk);
    v = ioOut;
    reN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitReady(input string tag);
    int n = 0;
    while (readyBusy !== 1'b1 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(tag, {7'd0, readyBusy}, 8'h01);
  endtask

  task automatic startRead(input logic [7:0] c, input logic [7:0] colB, input logic [7:0] pg);
    cmd(c); adr(colB); adr(pg); adr(8'h00);
    waitReady("R6 read ready");
  endtask

  task automatic statusIs(input string tag, input logic [7:0] exp);
    logic [7:0] v;
    cmd(8'h70);
    readByte(v);
    check(tag, v, exp);
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 ready after reset", {7'd0, readyBusy}, 8'h01);
    cmd(8'h70);
    readByte(v);
    check("R1 status after reset", v, 8'hC0);
  endtask

  task automatic testId();
    logic [7:0] v;
    cmd(8'h90); adr(8'h00);
    readByte(v); check("R2 maker byte", v, 8'h98);
    readByte(v); check("R2 device byte", v, 8'h75);
  endtask

  task automatic testProgram();
    logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h01); adr(8'h00);
    for (int i = 0; i < 4; i++) dat(8'h11 + 8'(i));
    cmd(8'h10);
    check("R3 busy after confirm", {7'd0, readyBusy}, 8'h00);
    waitReady("R3 program done");
    statusIs("R9 status pass", 8'hC0);
    startRead(8'h00, 8'h00, 8'h01);
    for (int i = 0; i < 4; i++) begin
      readByte(v); check("R3 readback", v, 8'h11 + 8'(i));
    end
    readByte(v); check("R3 untouched byte", v, 8'hFF);
  endtask

  task automatic testAreaB();
    logic [7:0] v;
    cmd(8'h01);
    cmd(8'h80); adr(8'h02); adr(8'h01); adr(8'h00); dat(8'h55); cmd(8'h10);
    waitReady("R4 prog B done");
    startRead(8'h01, 8'h02, 8'h01);
    readByte(v); check("R4 area B data at 258", v, 8'h55);
    // selection lapsed: program column 2 lands in the lower half
    cmd(8'h80); adr(8'h02); adr(8'h02); adr(8'h00); dat(8'h66); cmd(8'h10);
    waitReady("R4 prog after revert");
    startRead(8'h00, 8'h02, 8'h02);
    readByte(v); check("R4 one-shot revert to offset 0", v, 8'h66);
  endtask

  task automatic testAreaC();
    logic [7:0] v;
    startRead(8'h50, 8'h13, 8'h01);
    readByte(v); check("R5 spare col 515 erased", v, 8'hFF);
    cmd(8'h80); adr(8'h04); adr(8'h01); adr(8'h00); dat(8'h77); cmd(8'h10);
    waitReady("R5 prog in spare");
    startRead(8'h50, 8'h04, 8'h01);
    readByte(v); check("R5 spare persists, col 516", v, 8'h77);
    startRead(8'h00, 8'h04, 8'h01);
    readByte(v); check("R5 00h back to offset 0", v, 8'hFF);
  endtask

  task automatic testWrap();
    logic [7:0] v;
    startRead(8'h01, 8'hFA, 8'h00);
    for (int i = 0; i < 22; i++) readByte(v);
    check("R7 busy at page end", {7'd0, readyBusy}, 8'h00);
    waitReady("R7 wrap ready");
    readByte(v); check("R7 next page col 0", v, 8'h11);
    startRead(8'h50, 8'h0F, 8'h00);
    readByte(v); check("R7 col 527 page 0", v, 8'hFF);
    check("R7 busy at spare end", {7'd0, readyBusy}, 8'h00);
    waitReady("R7 spare wrap ready");
    for (int i = 0; i < 5; i++) readByte(v);
    check("R7 next page starts at 512", v, 8'h77);
    cmd(8'h00);
  endtask

  task automatic testFourthAddr();
    logic [7:0] v;
    cmd(8'h00); adr(8'h01); adr(8'h01); adr(8'h00); adr(8'h05);
    waitReady("R6 ready after 4 addr");
    readByte(v); check("R6 fourth address ignored", v, 8'h12);
  endtask

  task automatic testErase();
    logic [7:0] v;
    cmd(8'h60); adr(8'h01); adr(8'h00); cmd(8'hD0);
    check("R8 busy after erase confirm", {7'd0, readyBusy}, 8'h00);
    waitReady("R8 erase done");
    startRead(8'h00, 8'h00, 8'h01);
    readByte(v); check("R8 block erased", v, 8'hFF);
    startRead(8'h00, 8'h02, 8'h02);
    readByte(v); check("R8 other block kept", v, 8'h66);
  endtask

  task automatic testWpBlock();
    logic [7:0] v;
    @(negedge clk); wpN = 1'b0;
    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h00); dat(8'h00); cmd(8'h10);
    check("R10 no busy under protect", {7'd0, readyBusy}, 8'h01);
    statusIs("R10 status fail protected", 8'h41);
    @(negedge clk); wpN = 1'b1;
    startRead(8'h00, 8'h00, 8'h02);
    readByte(v); check("R10 array unchanged", v, 8'hFF);
  endtask

  task automatic testWpAbort();
    logic [7:0] v;
    cmd(8'h60); adr(8'h02); adr(8'h00); cmd(8'hD0);
    check("R11 erase busy", {7'd0, readyBusy}, 8'h00);
    repeat (5) @(negedge clk);
    wpN = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R11 ready after protect drop", {7'd0, readyBusy}, 8'h01);
    statusIs("R11 status fail", 8'h41);
    @(negedge clk); wpN = 1'b1;
    startRead(8'h00, 8'h02, 8'h02);
    readByte(v); check("R11 data survives", v, 8'h66);
  endtask

  task automatic testAbortAndIgnore();
    logic [7:0] v;
    cmd(8'h80); adr(8'h00); adr(8'h03); adr(8'h00); dat(8'h3C); cmd(8'h10);
    check("R3 program busy", {7'd0, readyBusy}, 8'h00);
    cmd(8'h70);
    readByte(v); check("R9 status while busy", v, 8'h80);
    cmd(8'h90); adr(8'h00);
    readByte(v); check("R13 ID ignored while busy", v, 8'h80);
    cmd(8'hFF);
    check("R12 ready after reset cmd", {7'd0, readyBusy}, 8'h01);
    statusIs("R12 fail cleared", 8'hC0);
    startRead(8'h00, 8'h00, 8'h03);
    readByte(v); check("R12 program aborted", v, 8'hFF);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; ceN = 1'b0; cle = 1'b0; ale = 1'b0; weN = 1'b1; reN = 1'b1;
    wpN = 1'b1; ioIn = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testId();
    testProgram();
    testAreaB();
    testAreaC();
    testWrap();
    testFourthAddr();
    testErase();
    testWpBlock();
    testWpAbort();
    testAbortAndIgnore();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule